// File: doc/BRIEF.md
# Circular Timestamp Record Store

This block holds time-tagged event records in a ring memory and publishes one 32-bit status word that tells software how far the ring has been filled. Each record arrives as four 32-bit fields in a single cycle: fine time, coarse time, seconds and metadata. It is stored as one 16-byte slot. The slot index is taken from a byte-granular write pointer. A wrap count in the upper bits of the same status word lets software tell a ring that has just filled from one that is still empty.

A small two-state controller gates storage. HALTED is the reset state, and in it record strobes are dropped. ACQUIRING is the state in which strobes are stored. The controller has four transitions:

- HALTED to ACQUIRING: on a start pulse. The pulse also clears the pointer and the wrap count.
- ACQUIRING to ACQUIRING on start: a restart, which also clears both counts.
- ACQUIRING to HALTED: on a stop pulse.
- Otherwise each state holds.

A DMA engine reads the stored words through a synchronous word port. The port has one cycle of latency.

Top module: `stamp_ring`

## Requirements
- R1: After reset, `status` is 0 and the controller is HALTED.
- R2: A stored record occupies byte offsets 0, 4, 8 and 12 of its slot. Those offsets hold fine, coarse, seconds and metadata, in that order. The metadata word is kept bit for bit: channel in [3:0], slope in [7:4] (1 rising, 0 falling), FIFO level flag in [11:8], FIFO empty flag in [15:12].
- R3: `status[11:0]` is the byte address of the next slot. It grows by 16 per stored record, so its low four bits are always 0.
- R4: After exactly 256 stored records from a start, `status[11:0]` is 0 and `status[31:12]` is 1. The wrap count increments whenever the pointer passes from 4080 to 0.
- R5: After 2580 stored records from a start (ten full wraps plus 20), `status[11:0]` is 320 and `status[31:12]` is 10.
- R6: A start pulse clears pointer and wrap count and enters ACQUIRING from either state. Start wins over a stop in the same cycle, and a record strobed in the same cycle as start is not stored.
- R7: A stop pulse enters HALTED. A record strobed in the same cycle as the stop is still stored. Later strobes leave `status` and the memory unchanged.
- R8: Record strobes while HALTED are ignored: `status` and all stored words are unchanged.
- R9: With `rd_en` high at a clock edge, `rd_data` shows the word at word address `rd_word_addr` (byte address divided by 4) from that edge onward. It holds while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start-acquisition pulse |
| cmd_stop | input | 1 | Stop-acquisition pulse |
| rec_valid | input | 1 | Record strobe |
| rec_fine | input | 32 | Fine time field (about 81 ps units) |
| rec_coarse | input | 32 | Coarse time field (8 ns units) |
| rec_secs | input | 32 | Seconds field |
| rec_meta | input | 32 | Metadata field |
| rd_en | input | 1 | Read request |
| rd_word_addr | input | 10 | Word address (byte address / 4) |
| rd_data | output | 32 | Read data, one cycle after request |
| status | output | 32 | {wrap count [31:12], byte write pointer [11:0]} |

## Verification
The hardest situation to reach from the ports is the pointer wrapping many times with a partial fill on top. This is what gives the 320/10 status value, and no short test can produce it. The stimulus issues a start and then streams 2580 back-to-back strobes, one per cycle. The bench keeps its own model of which slots each strobe should land in, so the latest words can be read back after many wraps. The same-cycle collisions are driven on purpose: start with a record, start with a stop, and stop with a record. Ignored strobes are checked by reading back slots that were filled earlier in the ring.

// File: rtl/stamp_ring_pkg.sv
package stamp_ring_pkg;
    typedef enum logic [0:0] {
        ST_HALTED    = 1'b0,
        ST_ACQUIRING = 1'b1
    } acq_state_t;

    localparam int WORD_W    = 32;
    localparam int LANES     = 4;
    localparam int LANE_BYTE = WORD_W / 8;
    localparam int REC_BYTES = LANES * LANE_BYTE;
endpackage

// File: rtl/stamp_ring_ctrl.sv
module stamp_ring_ctrl
    import stamp_ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic rec_valid,
    output logic acq_on,
    output logic clear_cnt,
    output logic store_en
);
    acq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (cmd_start) state_d = ST_ACQUIRING;
            end
            ST_ACQUIRING: begin
                if (cmd_start)     state_d = ST_ACQUIRING;
                else if (cmd_stop) state_d = ST_HALTED;
            end
            default: state_d = ST_HALTED;
        endcase
    end

    always_comb begin
        acq_on    = (state_q == ST_ACQUIRING);
        clear_cnt = cmd_start;
        store_en  = acq_on && rec_valid && !cmd_start;
    end
endmodule

// File: rtl/stamp_ring_ptr.sv
module stamp_ring_ptr #(
    parameter int PTR_W  = 12,
    parameter int WRAP_W = 20,
    parameter int STEP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [PTR_W-1:0]  ptr,
    output logic [WRAP_W-1:0] wraps
);
    localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);
    localparam logic [PTR_W-1:0] LAST_V = PTR_W'((1 << PTR_W) - STEP);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr   <= '0;
            wraps <= '0;
        end else if (advance) begin
            ptr <= ptr + STEP_V;
            if (ptr == LAST_V) wraps <= wraps + 1'b1;
        end
    end
endmodule

// File: rtl/stamp_ring_store.sv
module stamp_ring_store
    import stamp_ring_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [IDX_W-1:0]       widx,
    input  logic [WORD_W-1:0]      wdata [LANES],
    input  logic                   re,
    input  logic [IDX_W+SEL_W-1:0] raddr,
    output logic [WORD_W-1:0]      rdata
);
    logic [WORD_W-1:0] lane_q [LANES];
    logic [SEL_W-1:0]  sel_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] mem [DEPTH];
        logic [WORD_W-1:0] q;

        always_ff @(posedge clk) begin
            if (we) mem[widx] <= wdata[g];
            if (re) q <= mem[raddr[IDX_W+SEL_W-1:SEL_W]];
        end

        assign lane_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (re) sel_q <= raddr[SEL_W-1:0];
    end

    assign rdata = lane_q[sel_q];
endmodule

// File: rtl/stamp_ring.sv
module stamp_ring
    import stamp_ring_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int STATUS_W = 32,
    localparam int PTR_W  = $clog2(DEPTH * REC_BYTES),
    localparam int WRAP_W = STATUS_W - PTR_W,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WADR_W = PTR_W - $clog2(LANE_BYTE)
) (
    input  logic                cmd_start,
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_stop,
    input  logic                rec_valid,
    input  logic [WORD_W-1:0]   rec_fine,
    input  logic [WORD_W-1:0]   rec_coarse,
    input  logic [WORD_W-1:0]   rec_secs,
    input  logic [WORD_W-1:0]   rec_meta,
    input  logic                rd_en,
    input  logic [WADR_W-1:0]   rd_word_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic [STATUS_W-1:0] status
);
    localparam int SLOT_SH = $clog2(REC_BYTES);

    logic              acq_on;
    logic              clear_cnt;
    logic              store_en;
    logic [PTR_W-1:0]  wr_ptr;
    logic [WRAP_W-1:0] wrap_cnt;
    logic [WORD_W-1:0] lanes_in [LANES];

    assign lanes_in[0] = rec_fine;
    assign lanes_in[1] = rec_coarse;
    assign lanes_in[2] = rec_secs;
    assign lanes_in[3] = rec_meta;

    stamp_ring_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .rec_valid (rec_valid),
        .acq_on    (acq_on),
        .clear_cnt (clear_cnt),
        .store_en  (store_en)
    );

    stamp_ring_ptr #(
        .PTR_W  (PTR_W),
        .WRAP_W (WRAP_W),
        .STEP   (REC_BYTES)
    ) i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_cnt),
        .advance (store_en),
        .ptr     (wr_ptr),
        .wraps   (wrap_cnt)
    );

    stamp_ring_store #(
        .DEPTH (DEPTH)
    ) i_store (
        .clk   (clk),
        .we    (store_en),
        .widx  (wr_ptr[PTR_W-1:SLOT_SH]),
        .wdata (lanes_in),
        .re    (rd_en),
        .raddr (rd_word_addr),
        .rdata (rd_data)
    );

    assign status = {wrap_cnt, wr_ptr};
endmodule

// File: rtl/stamp_ring_chk.sv
module stamp_ring_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_start,
    input logic        cmd_stop,
    input logic        rec_valid,
    input logic        acq_on,
    input logic [31:0] status
);
    // R3
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[3:0] == 4'h0);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_on && rec_valid && !cmd_start |=> status[11:0] == $past(status[11:0]) + 12'd16);

    // R4
    wrap_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_on && rec_valid && !cmd_start && status[11:0] == 12'd4080
        |=> status[31:12] == $past(status[31:12]) + 20'd1);

    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> status == 32'h0 && acq_on);

    // R7
    stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop && !cmd_start |=> !acq_on);

    // R8
    halted_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_on && !cmd_start |=> $stable(status));
endmodule

bind stamp_ring stamp_ring_chk i_stamp_ring_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .rec_valid (rec_valid),
    .acq_on    (acq_on),
    .status    (status)
);

// File: tb/test_stamp_ring.sv
module test_stamp_ring;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        rec_valid = 1'b0;
    logic [31:0] rec_fine = '0;
    logic [31:0] rec_coarse = '0;
    logic [31:0] rec_secs = '0;
    logic [31:0] rec_meta = '0;
    logic        rd_en = 1'b0;
    logic [9:0]  rd_word_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_mem [1024];
    int mptr = 0;

    always #2.5 clk = ~clk;

    stamp_ring i_stamp_ring (
        .cmd_start    (cmd_start),
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_stop     (cmd_stop),
        .rec_valid    (rec_valid),
        .rec_fine     (rec_fine),
        .rec_coarse   (rec_coarse),
        .rec_secs     (rec_secs),
        .rec_meta     (rec_meta),
        .rd_en        (rd_en),
        .rd_word_addr (rd_word_addr),
        .rd_data      (rd_data),
        .status       (status)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input int wraps, input int ptr);
        return {wraps[19:0], ptr[11:0]};
    endfunction

    // drive one record's fields for sequence number n
    task automatic drive_rec(input int n);
        rec_fine   = 32'h0001_0000 + n;
        rec_coarse = 32'h2000_0000 + n;
        rec_secs   = 32'h5EC0_0000 + n;
        rec_meta   = {16'h0, 4'h1, 4'h0, 4'h1, n[3:0]};
    endtask

    task automatic model_store();
        exp_mem[(mptr / 4) + 0] = rec_fine;
        exp_mem[(mptr / 4) + 1] = rec_coarse;
        exp_mem[(mptr / 4) + 2] = rec_secs;
        exp_mem[(mptr / 4) + 3] = rec_meta;
        mptr = (mptr + 16) % 4096;
    endtask

    task automatic push(input int count, input int base, input bit stored);
        for (int k = 0; k < count; k++) begin
            @(negedge clk);
            rec_valid = 1'b1;
            drive_rec(base + k);
            if (stored) model_store();
        end
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic cmd(input bit s, input bit p, input bit v, input int n, input bit stored);
        @(negedge clk);
        cmd_start = s;
        cmd_stop  = p;
        rec_valid = v;
        drive_rec(n);
        if (stored) model_store();
        if (s) mptr = 0;
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_stop  = 1'b0;
        rec_valid = 1'b0;
    endtask

    task automatic rd_chk(input int waddr, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        rd_word_addr = waddr[9:0];
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data, exp, req);
    endtask

    task automatic t_reset();
        chk(status, 32'h0, "R1 reset status");
        cmd(1'b0, 1'b0, 1'b1, 99, 1'b0);
        chk(status, 32'h0, "R8 strobe after reset ignored");
    endtask

    task automatic t_basic();
        cmd(1'b1, 1'b0, 1'b0, 0, 1'b0);
        chk(status, 32'h0, "R6 start clears");
        push(3, 500, 1'b1);
        chk(status, st(0, 48), "R3 pointer after 3 records");
        rd_chk(4, 32'h0001_01F5, "R2 fine word slot1");
        rd_chk(5, 32'h2000_01F5, "R2 coarse word slot1");
        rd_chk(6, 32'h5EC0_01F5, "R2 seconds word slot1");
        rd_chk(7, 32'h0000_1015, "R2 metadata word slot1 ch5 rising");
        rd_chk(11, exp_mem[11], "R2 metadata slot2");
        @(negedge clk);
        chk(rd_data, exp_mem[11], "R9 rd_data held with rd_en low");
    endtask

    task automatic t_restart();
        cmd(1'b1, 1'b1, 1'b0, 0, 1'b0);
        chk(status, 32'h0, "R6 start beats stop, counts cleared");
        push(1, 0, 1'b1);
        chk(status, st(0, 16), "R6 still acquiring after start+stop");
        cmd(1'b1, 1'b0, 1'b1, 77, 1'b0);
        chk(status, 32'h0, "R6 record with start dropped");
    endtask

    task automatic t_wrap_once();
        push(255, 1000, 1'b1);
        chk(status, st(0, 4080), "R3 pointer at last slot");
        push(1, 1255, 1'b1);
        chk(status, st(1, 0), "R4 one wrap after 256 records");
    endtask

    task automatic t_stop();
        cmd(1'b0, 1'b1, 1'b1, 3000, 1'b1);
        chk(status, st(1, 16), "R7 record with stop stored");
        push(4, 4000, 1'b0);
        chk(status, st(1, 16), "R7 strobes after stop ignored");
        rd_chk(0, exp_mem[0], "R7 slot0 holds stop-cycle record");
        rd_chk(4, exp_mem[4], "R8 slot1 fine unchanged while halted");
        rd_chk(7, exp_mem[7], "R8 slot1 meta unchanged while halted");
    endtask

    task automatic t_long();
        cmd(1'b1, 1'b0, 1'b0, 0, 1'b0);
        chk(status, 32'h0, "R6 restart from halted");
        push(2580, 10000, 1'b1);
        chk(status, st(10, 320), "R5 ten wraps plus 20");
        rd_chk(76, exp_mem[76], "R5 last record fine");
        rd_chk(79, exp_mem[79], "R5 last record meta");
        rd_chk(80, exp_mem[80], "R9 slot20 from previous wrap");
        cmd(1'b0, 1'b1, 1'b0, 0, 1'b0);
        push(2, 7000, 1'b0);
        chk(status, st(10, 320), "R8 halted strobes leave status");
        rd_chk(80, exp_mem[80], "R8 slot20 unchanged");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_restart();
        t_wrap_once();
        t_stop();
        t_long();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule